// File: doc/BRIEF.md
# Overload Fault Integrating Supervisor

This block is the digital fault supervisor of a switching power controller. A slow time-base pulse, one clock cycle wide, paces an up/down counter. On each pulse the counter climbs while the peak-current-limit comparator reports an over-limit condition and falls while it does not, never going below zero. Overload time therefore builds up over time and also drains away. When the net count reaches a completion value (8 by default, which is 80 ms at a 10 ms pulse), the gate drive is switched off and the block enters a fault state. A separate fast winding-short input skips the counter and shuts the drive off on the next clock edge.

A static strap selects what follows a fault. In auto-recovery mode the block keeps the drive off until the supply reports undervoltage. It then clears the count, sends a one-cycle restart request and resumes switching. In latched mode it also drives a supply pull-down request. It ignores undervoltage and stays in the fault state until the supply reports that its current has fallen below the latch-hold level. The comparators, blanking and supply regulation sit outside the block and arrive as synchronous digital inputs.

Top module: `ovl_supervisor`

## Requirements
- R1: After a synchronous reset, drv_en=1, fault=0, clamp_en=0, restart=0 and count=0.
- R2: While running, a clock with tick=1 and ilim=1 (short=0) raises count by exactly 1. A clock with tick=0 leaves count unchanged.
- R3: While running, a clock with tick=1 and ilim=0 lowers count by 1, and count stays at 0 when it is already 0.
- R4: On the clock edge where count reaches LIMIT (8), fault becomes 1 and drv_en becomes 0. Count shows 8.
- R5: With latch_mode=0, a fault holds drv_en=0 and clamp_en=0 until a clock with vcc_off=1. That edge returns to running with count=0, drv_en=1, and restart=1 for exactly one cycle.
- R6: With latch_mode=1, a fault sets clamp_en=1. vcc_off has no effect. A clock with unlatch=1 returns to running with clamp_en=0, count=0 and a one-cycle restart.
- R7: While running, a clock with short=1 enters the fault state on that edge, and count keeps the value it had before that edge even if tick and ilim are 1.
- R8: A short-triggered fault follows latch_mode exactly as an overload fault does (clamp_en=1 only when latch_mode=1).
- R9: In any fault state, tick, ilim and short leave count unchanged.
- R10: drv_en is 0 in every cycle where fault is 1, and clamp_en is never 1 without fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle time-base pulse that paces the counter |
| ilim | input | 1 | Peak-current-limit comparator output |
| short_det | input | 1 | Winding-short comparator output |
| latch_mode | input | 1 | Strap: 0 = auto-recovery, 1 = latched |
| vcc_off | input | 1 | Supply undervoltage indication |
| unlatch | input | 1 | Supply current below latch-hold level |
| drv_en | output | 1 | Gate-drive enable |
| fault | output | 1 | Block is in a fault state |
| clamp_en | output | 1 | Supply pull-down request (latched fault) |
| restart | output | 1 | One-cycle restart request on leaving a fault |
| count | output | CNT_W | Current overload count |

## Verification
Every result (count step, fault entry, release and the restart pulse) appears one clock edge after the input that causes it is presented. No output has a longer path through registers. The bench drives each stimulus on the falling edge, waits for the next rising edge and samples one time unit later. Each check therefore looks at the first cycle in which the result is due. Hold-type requirements, such as ignored vcc_off in latched mode or ignored ticks during a fault, are checked by reading count and the status outputs right after the stimulus edge and before any release input is applied.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_HOLD  = 2'd1,
        ST_LATCH = 2'd2
    } sup_state_e;

    typedef struct packed {
        logic drv_en;
        logic fault;
        logic clamp_en;
    } sup_out_s;

    function automatic sup_out_s decode_state(input sup_state_e s);
        sup_out_s o;
        o.drv_en   = (s == ST_RUN);
        o.fault    = (s != ST_RUN);
        o.clamp_en = (s == ST_LATCH);
        return o;
    endfunction

    function automatic sup_state_e fault_target(input logic latched);
        return latched ? ST_LATCH : ST_HOLD;
    endfunction

endpackage

// File: rtl/ovl_integrator.sv
module ovl_integrator #(
    parameter int LIMIT = 8,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             ilim,
    input  logic             run_en,
    input  logic             freeze,
    input  logic             clear,
    output logic [CNT_W-1:0] count,
    output logic             done
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic [CNT_W-1:0] count_q, count_d;

    always_comb begin
        count_d = count_q;
        if (clear) begin
            count_d = '0;
        end else if (run_en && tick && !freeze) begin
            if (ilim)
                count_d = count_q + ONE;
            else if (count_q != '0)
                count_d = count_q - ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) count_q <= '0;
        else     count_q <= count_d;
    end

    assign count = count_q;
    assign done  = run_en && tick && ilim && (count_q == LAST);

    // R2: counter rises by one per over-limit tick while running
    p_step_up_r2: assert property (@(posedge clk) disable iff (rst)
        (run_en && tick && ilim && !freeze && !clear) |=> (count_q == $past(count_q) + ONE));

    // R2: no tick, no change while running
    p_no_tick_r2: assert property (@(posedge clk) disable iff (rst)
        (run_en && !tick && !clear) |=> $stable(count_q));

    // R3: floor at zero
    p_floor_r3: assert property (@(posedge clk) disable iff (rst)
        (run_en && tick && !ilim && count_q == '0 && !clear) |=> (count_q == '0));

    // R9: frozen outside the running state
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!run_en && !clear) |=> $stable(count_q));

    // R4: never beyond completion value
    p_bound_r4: assert property (@(posedge clk) disable iff (rst)
        count_q <= CNT_W'(LIMIT));

endmodule

// File: rtl/ovl_fault_fsm.sv
module ovl_fault_fsm
    import ovl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       short_det,
    input  logic       done,
    input  logic       latch_mode,
    input  logic       vcc_off,
    input  logic       unlatch,
    output sup_state_e state,
    output logic       release_now
);
    sup_state_e state_q, state_d;

    always_comb begin
        state_d     = state_q;
        release_now = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (short_det || done)
                    state_d = fault_target(latch_mode);
            end
            ST_HOLD: begin
                if (vcc_off) begin
                    state_d     = ST_RUN;
                    release_now = 1'b1;
                end
            end
            ST_LATCH: begin
                if (unlatch) begin
                    state_d     = ST_RUN;
                    release_now = 1'b1;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_RUN;
        else     state_q <= state_d;
    end

    assign state = state_q;

    // R7: a short while running leaves the running state at once
    p_short_trip_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && short_det) |=> (state_q != ST_RUN));

    // R6: vcc_off alone never frees a latched fault
    p_latch_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LATCH && !unlatch) |=> (state_q == ST_LATCH));

    // R5: auto-recovery waits for undervoltage
    p_auto_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HOLD && !vcc_off) |=> (state_q == ST_HOLD));

endmodule

// File: rtl/ovl_out_stage.sv
module ovl_out_stage
    import ovl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  sup_state_e state,
    input  logic       release_now,
    output logic       drv_en,
    output logic       fault,
    output logic       clamp_en,
    output logic       restart
);
    sup_out_s dec;
    logic     restart_q;

    always_comb dec = decode_state(state);

    always_ff @(posedge clk) begin
        if (rst) restart_q <= 1'b0;
        else     restart_q <= release_now;
    end

    assign drv_en   = dec.drv_en;
    assign fault    = dec.fault;
    assign clamp_en = dec.clamp_en;
    assign restart  = restart_q;

    // R10: drive off in every fault cycle
    p_drv_off_r10: assert property (@(posedge clk) disable iff (rst)
        fault |-> !drv_en);

    // R10: clamp only inside a fault
    p_clamp_fault_r10: assert property (@(posedge clk) disable iff (rst)
        clamp_en |-> fault);

    // R5: restart request lasts one cycle and coincides with running
    p_restart_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        restart |=> !restart);

    p_restart_run_r5: assert property (@(posedge clk) disable iff (rst)
        restart |-> drv_en);

endmodule

// File: rtl/ovl_supervisor.sv
module ovl_supervisor
    import ovl_pkg::*;
#(
    parameter int LIMIT = 8,
    parameter int CNT_W = $clog2(LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             ilim,
    input  logic             short_det,
    input  logic             latch_mode,
    input  logic             vcc_off,
    input  logic             unlatch,
    output logic             drv_en,
    output logic             fault,
    output logic             clamp_en,
    output logic             restart,
    output logic [CNT_W-1:0] count
);
    sup_state_e state;
    logic       release_now;
    logic       done;
    logic       run_en;

    assign run_en = (state == ST_RUN);

    ovl_integrator #(.LIMIT(LIMIT), .CNT_W(CNT_W)) u_integ (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .ilim   (ilim),
        .run_en (run_en),
        .freeze (short_det),
        .clear  (release_now),
        .count  (count),
        .done   (done)
    );

    ovl_fault_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .short_det   (short_det),
        .done        (done),
        .latch_mode  (latch_mode),
        .vcc_off     (vcc_off),
        .unlatch     (unlatch),
        .state       (state),
        .release_now (release_now)
    );

    ovl_out_stage u_out (
        .clk         (clk),
        .rst         (rst),
        .state       (state),
        .release_now (release_now),
        .drv_en      (drv_en),
        .fault       (fault),
        .clamp_en    (clamp_en),
        .restart     (restart)
    );

    // R5: a restart always begins from an empty count
    p_restart_clear_r5: assert property (@(posedge clk) disable iff (rst)
        restart |-> (count == '0));

    // R4: reaching completion coincides with a fault
    p_full_fault_r4: assert property (@(posedge clk) disable iff (rst)
        (count == CNT_W'(LIMIT)) |-> fault);

endmodule

// File: tb/ovl_supervisor_tb.sv
module ovl_supervisor_tb;

    localparam int LIMIT = 8;
    localparam int CNT_W = 4;

    logic clk = 1'b0;
    logic rst, tick, ilim, short_det, latch_mode, vcc_off, unlatch;
    logic drv_en, fault, clamp_en, restart;
    logic [CNT_W-1:0] count;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    ovl_supervisor #(.LIMIT(LIMIT), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .tick(tick), .ilim(ilim), .short_det(short_det),
        .latch_mode(latch_mode), .vcc_off(vcc_off), .unlatch(unlatch),
        .drv_en(drv_en), .fault(fault), .clamp_en(clamp_en),
        .restart(restart), .count(count)
    );

    // {tick, ilim, short, exp_fault, exp_count[3:0]}
    localparam int NVEC = 14;
    localparam logic [7:0] VEC [NVEC] = '{
        8'b110_0_0001, 8'b110_0_0010, 8'b010_0_0010, 8'b100_0_0001,
        8'b100_0_0000, 8'b100_0_0000, 8'b110_0_0001, 8'b110_0_0010,
        8'b110_0_0011, 8'b110_0_0100, 8'b110_0_0101, 8'b110_0_0110,
        8'b110_0_0111, 8'b110_1_1000
    };

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input logic t, input logic i, input logic s,
                        input logic v, input logic u);
        @(negedge clk);
        tick = t; ilim = i; short_det = s; vcc_off = v; unlatch = u;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input logic mode);
        @(negedge clk);
        latch_mode = mode; rst = 1'b1;
        tick = 0; ilim = 0; short_det = 0; vcc_off = 0; unlatch = 0;
        @(posedge clk); #1;
        @(negedge clk); rst = 1'b0;
    endtask

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1; tick = 0; ilim = 0; short_det = 0; latch_mode = 0;
        vcc_off = 0; unlatch = 0;

        // R1: reset state
        do_reset(1'b0);
        chk("R1 drv_en", int'(drv_en), 1);
        chk("R1 fault", int'(fault), 0);
        chk("R1 clamp_en", int'(clamp_en), 0);
        chk("R1 restart", int'(restart), 0);
        chk("R1 count", int'(count), 0);

        // R2 / R3 / R4: table walk in auto-recovery mode
        for (int k = 0; k < NVEC; k++) begin
            step(VEC[k][7], VEC[k][6], VEC[k][5], 1'b0, 1'b0);
            chk("R2/R3 count", int'(count), int'(VEC[k][3:0]));
            chk("R4 fault", int'(fault), int'(VEC[k][4]));
        end
        chk("R4 drv_en off", int'(drv_en), 0);
        chk("R10 drv off in fault", int'(drv_en & fault), 0);
        chk("R5 no clamp in auto", int'(clamp_en), 0);

        // R9: ticks, limit and short ignored during fault
        step(1, 1, 1, 0, 0);
        step(1, 0, 0, 0, 0);
        chk("R9 count frozen", int'(count), 8);
        chk("R5 still held", int'(fault), 1);

        // R5: undervoltage releases
        step(0, 0, 0, 1, 0);
        chk("R5 drv_en", int'(drv_en), 1);
        chk("R5 restart", int'(restart), 1);
        chk("R5 count cleared", int'(count), 0);
        step(0, 0, 0, 0, 0);
        chk("R5 restart one cycle", int'(restart), 0);

        // R7: short while running, count kept
        step(1, 1, 0, 0, 0);
        step(1, 1, 0, 0, 0);
        step(1, 1, 0, 0, 0);
        step(1, 1, 1, 0, 0);
        chk("R7 fault", int'(fault), 1);
        chk("R7 count kept", int'(count), 3);
        chk("R8 auto no clamp", int'(clamp_en), 0);
        step(0, 0, 0, 1, 0);
        chk("R8 auto release", int'(drv_en), 1);

        // R6: latched overload
        do_reset(1'b1);
        for (int k = 0; k < LIMIT; k++) step(1, 1, 0, 0, 0);
        chk("R6 fault", int'(fault), 1);
        chk("R6 clamp_en", int'(clamp_en), 1);
        step(0, 0, 0, 1, 0);
        chk("R6 vcc_off ignored fault", int'(fault), 1);
        chk("R6 vcc_off ignored clamp", int'(clamp_en), 1);
        chk("R6 vcc_off ignored restart", int'(restart), 0);
        step(0, 0, 0, 0, 1);
        chk("R6 unlatch drv_en", int'(drv_en), 1);
        chk("R6 unlatch clamp off", int'(clamp_en), 0);
        chk("R6 unlatch count", int'(count), 0);
        chk("R6 unlatch restart", int'(restart), 1);

        // R8: latched short
        step(1, 1, 0, 0, 0);
        step(0, 0, 1, 0, 0);
        chk("R8 latched short clamp", int'(clamp_en), 1);
        chk("R8 latched short count", int'(count), 1);
        chk("R10 drv off", int'(drv_en), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule